// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits between a small host processor and a parallel NOR flash device with a 22-bit address bus and a 16-bit data bus. The host raises one of three single-cycle requests: read, program or chip erase. The sequencer turns each request into the bus activity the flash expects. A read opens the output enable for a fixed number of clocks and captures the word. Program and erase step through hard-coded unlock and command writes, and each write is split into three clock phases: set up, WE# low, WE# high.

A program request runs the three unlock and command writes on its own, then waits. The fourth write carries the user's sector, offset and data word, and it starts only when the host pulses a separate data strobe. A chip erase runs all six writes without a pause. Chip enable stays low permanently, so WE# alone frames each write. The flash takes the address on the falling edge of WE# and the data on the rising edge. A busy flag covers every operation. Requests that arrive while it is set are dropped. A one-cycle done pulse marks completion.

Top module: `nor_cmd_seq`

## Requirements
- R1: Chip enable is low at all times. Right after reset, WE# and OE# are high, the data bus is not driven, and busy and done are low.
- R2: A program request writes address 0x555 with data 0xAA, then 0x2AA with 0x55, then 0x555 with 0xA0. It then holds with busy high and WE# high.
- R3: The fourth program write starts only on a data strobe received while the program is held. Busy stays high through the hold, and WE# is high whenever busy is low.
- R4: The fourth program write places the sector number on address bits 21..15 and the offset on bits 14..0. It writes the host data word latched at the strobe.
- R5: A chip-erase request performs six writes in this order: 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10.
- R6: After the last write of an operation, done is high for exactly one cycle. That is the first cycle in which busy is low.
- R7: A read holds OE# low and WE# high for RD_CYCLES clocks, with the bus released and the latched {sector, offset} address applied. The word on the flash data lines in the last of those clocks appears on rdData when done rises.
- R8: Read, program and erase requests that arrive while busy is high have no effect.
- R9: If several requests arrive in the same idle cycle, erase wins over program, and program wins over read.
- R10: Each write lasts three clocks, with WE# low for exactly one of them. Address and data are held through the whole write. OE# is high and the bus is driven while WE# is low.
- R11: A data strobe received while no program is held starts no write and raises neither busy nor done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReq | input | 1 | Read request, single cycle |
| pgmReq | input | 1 | Program request, single cycle |
| ersReq | input | 1 | Chip-erase request, single cycle |
| dataStrobe | input | 1 | Starts the final program write |
| hostSector | input | 7 | Sector number |
| hostOffset | input | 15 | Word offset inside the sector |
| hostData | input | 16 | Data word to program |
| flashDqIn | input | 16 | Data lines read back from the flash |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Last word read |
| flashAddr | output | 22 | Flash address bus |
| flashDqOut | output | 16 | Data driven toward the flash |
| flashDqOe | output | 1 | High while the sequencer drives the data lines |
| flashCeN | output | 1 | Chip enable, active low |
| flashOeN | output | 1 | Output enable, active low |
| flashWeN | output | 1 | Write enable, active low |

## Verification
The two functions that can fall in the same cycle are request arbitration and the ongoing write sequence. Tests provoke both. Erase, program and read requests are raised together in one idle cycle, and the bench judges which command bytes appear on the bus. New requests are also injected in the middle of an erase, and the bench confirms that exactly the six erase writes reach the flash and that a single done pulse follows. A bus monitor records the address at each WE# fall and the data at each WE# rise. It compares the recorded sequence with the expected command table.

// File: rtl/norseq_pkg.sv
package norseq_pkg;

  localparam int CMD_ADDR_W = 11;
  localparam int CMD_DATA_W = 8;
  localparam int CMD_W      = CMD_ADDR_W + CMD_DATA_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_HOLD  = 2'd2,
    ST_READ  = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       latchHost;
    logic       useHost;
    logic       isErase;
    logic [2:0] step;
    logic       weLow;
    logic       rdPhase;
    logic       driveDq;
    logic       capRead;
  } seqStrobe_t;

  // command table: {address, data} for each write step
  function automatic logic [CMD_W-1:0] cmdWord(input logic isErase, input logic [2:0] step);
    logic [CMD_W-1:0] w;
    case (step)
      3'd0, 3'd3: w = {11'h555, 8'hAA};
      3'd1, 3'd4: w = {11'h2AA, 8'h55};
      3'd2:       w = isErase ? {11'h555, 8'h80} : {11'h555, 8'hA0};
      3'd5:       w = {11'h555, 8'h10};
      default:    w = '0;
    endcase
    if (!isErase && step == 3'd3) w = '0;
    return w;
  endfunction

endpackage

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import norseq_pkg::*;
#(
  parameter int RD_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdReq,
  input  logic       pgmReq,
  input  logic       ersReq,
  input  logic       dataStrobe,
  output logic       busy,
  output logic       done,
  output seqStrobe_t ctl
);

  localparam int RD_W = (RD_CYCLES > 1) ? $clog2(RD_CYCLES) : 1;
  localparam logic [RD_W-1:0] RD_LAST = RD_W'(RD_CYCLES - 1);
  localparam logic [2:0] PGM_LAST  = 3'd3;
  localparam logic [2:0] ERS_LAST  = 3'd5;
  localparam logic [2:0] PGM_PAUSE = 3'd2;
  localparam logic [1:0] PH_SETUP  = 2'd0;
  localparam logic [1:0] PH_END    = 2'd2;

  seqState_t       state, stateNx;
  logic            eraseQ, eraseNx;
  logic [2:0]      stepQ, stepNx;
  logic [1:0]      phaseQ, phaseNx;
  logic [RD_W-1:0] rdCntQ, rdCntNx;
  logic            doneNx;
  logic            latchNx;
  logic            capNx;
  logic [2:0]      lastStep;

  assign lastStep = eraseQ ? ERS_LAST : PGM_LAST;

  always_comb begin
    stateNx = state;
    eraseNx = eraseQ;
    stepNx  = stepQ;
    phaseNx = phaseQ;
    rdCntNx = rdCntQ;
    doneNx  = 1'b0;
    latchNx = 1'b0;
    capNx   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        stepNx  = '0;
        phaseNx = PH_SETUP;
        rdCntNx = '0;
        if (ersReq) begin
          stateNx = ST_WRITE;
          eraseNx = 1'b1;
        end else if (pgmReq) begin
          stateNx = ST_WRITE;
          eraseNx = 1'b0;
        end else if (rdReq) begin
          stateNx = ST_READ;
          latchNx = 1'b1;
        end
      end
      ST_WRITE: begin
        if (phaseQ != PH_END) begin
          phaseNx = phaseQ + 2'd1;
        end else if (stepQ == lastStep) begin
          stateNx = ST_IDLE;
          doneNx  = 1'b1;
        end else if (!eraseQ && stepQ == PGM_PAUSE) begin
          stateNx = ST_HOLD;
        end else begin
          stepNx  = stepQ + 3'd1;
          phaseNx = PH_SETUP;
        end
      end
      ST_HOLD: begin
        if (dataStrobe) begin
          latchNx = 1'b1;
          stateNx = ST_WRITE;
          stepNx  = PGM_LAST;
          phaseNx = PH_SETUP;
        end
      end
      ST_READ: begin
        if (rdCntQ == RD_LAST) begin
          capNx   = 1'b1;
          stateNx = ST_IDLE;
          doneNx  = 1'b1;
        end else begin
          rdCntNx = rdCntQ + RD_W'(1);
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      eraseQ <= 1'b0;
      stepQ  <= '0;
      phaseQ <= PH_SETUP;
      rdCntQ <= '0;
      done   <= 1'b0;
    end else begin
      state  <= stateNx;
      eraseQ <= eraseNx;
      stepQ  <= stepNx;
      phaseQ <= phaseNx;
      rdCntQ <= rdCntNx;
      done   <= doneNx;
    end
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    ctl           = '0;
    ctl.latchHost = latchNx;
    ctl.capRead   = capNx;
    ctl.isErase   = eraseQ;
    ctl.step      = stepQ;
    ctl.driveDq   = (state == ST_WRITE);
    ctl.weLow     = (state == ST_WRITE) && phaseQ[0];
    ctl.rdPhase   = (state == ST_READ);
    ctl.useHost   = (state == ST_READ) || (state == ST_WRITE && !eraseQ && stepQ == PGM_LAST);
  end

endmodule

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import norseq_pkg::*;
#(
  parameter int SECT_W = 7,
  parameter int OFF_W  = 15,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               ctl,
  input  logic [SECT_W-1:0]        hostSector,
  input  logic [OFF_W-1:0]         hostOffset,
  input  logic [DATA_W-1:0]        hostData,
  input  logic [DATA_W-1:0]        flashDqIn,
  output logic [SECT_W+OFF_W-1:0]  flashAddr,
  output logic [DATA_W-1:0]        flashDqOut,
  output logic                     flashDqOe,
  output logic                     flashOeN,
  output logic                     flashWeN,
  output logic [DATA_W-1:0]        rdData
);

  localparam int ADDR_W = SECT_W + OFF_W;

  logic [ADDR_W-1:0] hostAddrQ;
  logic [DATA_W-1:0] hostDataQ;
  logic [CMD_W-1:0]  cmd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostAddrQ <= '0;
      hostDataQ <= '0;
      rdData    <= '0;
    end else begin
      if (ctl.latchHost) begin
        hostAddrQ <= {hostSector, hostOffset};
        hostDataQ <= hostData;
      end
      if (ctl.capRead) rdData <= flashDqIn;
    end
  end

  assign cmd        = cmdWord(ctl.isErase, ctl.step);
  assign flashAddr  = ctl.useHost ? hostAddrQ : ADDR_W'(cmd[CMD_W-1:CMD_DATA_W]);
  assign flashDqOut = ctl.useHost ? hostDataQ : DATA_W'(cmd[CMD_DATA_W-1:0]);
  assign flashDqOe  = ctl.driveDq;
  assign flashOeN   = ~ctl.rdPhase;
  assign flashWeN   = ~ctl.weLow;

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import norseq_pkg::*;
#(
  parameter int SECT_W    = 7,
  parameter int OFF_W     = 15,
  parameter int DATA_W    = 16,
  parameter int RD_CYCLES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    rdReq,
  input  logic                    pgmReq,
  input  logic                    ersReq,
  input  logic                    dataStrobe,
  input  logic [SECT_W-1:0]       hostSector,
  input  logic [OFF_W-1:0]        hostOffset,
  input  logic [DATA_W-1:0]       hostData,
  input  logic [DATA_W-1:0]       flashDqIn,
  output logic                    busy,
  output logic                    done,
  output logic [DATA_W-1:0]       rdData,
  output logic [SECT_W+OFF_W-1:0] flashAddr,
  output logic [DATA_W-1:0]       flashDqOut,
  output logic                    flashDqOe,
  output logic                    flashCeN,
  output logic                    flashOeN,
  output logic                    flashWeN
);

  seqStrobe_t ctl;

  nor_seq_ctrl #(.RD_CYCLES(RD_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .pgmReq(pgmReq), .ersReq(ersReq),
    .dataStrobe(dataStrobe), .busy(busy), .done(done), .ctl(ctl)
  );

  nor_seq_dp #(.SECT_W(SECT_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .hostSector(hostSector), .hostOffset(hostOffset),
    .hostData(hostData), .flashDqIn(flashDqIn), .flashAddr(flashAddr),
    .flashDqOut(flashDqOut), .flashDqOe(flashDqOe), .flashOeN(flashOeN),
    .flashWeN(flashWeN), .rdData(rdData)
  );

  assign flashCeN = 1'b0;

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] flashAddr,
  input logic [DATA_W-1:0] flashDqOut,
  input logic              flashDqOe,
  input logic              flashOeN,
  input logic              flashWeN
);

  // R10
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> (flashOeN && flashDqOe));

  // R10
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |=> flashWeN);

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashWeN) |-> ($stable(flashAddr) && $stable(flashDqOut)));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R3
  idle_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> flashWeN);

  // R7
  read_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flashOeN |-> (flashWeN && !flashDqOe));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.ADDR_W(SECT_W + OFF_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .flashAddr(flashAddr),
  .flashDqOut(flashDqOut), .flashDqOe(flashDqOe), .flashOeN(flashOeN), .flashWeN(flashWeN)
);

// File: tb/nor_cmd_seq_bench.sv
`timescale 1ns/1ps
module nor_cmd_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdReq = 1'b0, pgmReq = 1'b0, ersReq = 1'b0, dataStrobe = 1'b0;
  logic [6:0]  hostSector = '0;
  logic [14:0] hostOffset = '0;
  logic [15:0] hostData = '0;
  logic [15:0] flashDqIn;
  logic        busy, done, flashDqOe, flashCeN, flashOeN, flashWeN;
  logic [15:0] rdData, flashDqOut;
  logic [21:0] flashAddr;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit finished = 0;
  int recN = 0, doneCnt = 0, lowLen = 0;
  logic [21:0] recAddr [0:15];
  logic [15:0] recData [0:15];
  logic prevWe = 1'b1;

  always #4 clk = ~clk;

  assign flashDqIn = flashAddr[15:0] ^ 16'h5A5A;

  nor_cmd_seq u_nor_cmd_seq (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .pgmReq(pgmReq), .ersReq(ersReq),
    .dataStrobe(dataStrobe), .hostSector(hostSector), .hostOffset(hostOffset),
    .hostData(hostData), .flashDqIn(flashDqIn), .busy(busy), .done(done),
    .rdData(rdData), .flashAddr(flashAddr), .flashDqOut(flashDqOut),
    .flashDqOe(flashDqOe), .flashCeN(flashCeN), .flashOeN(flashOeN), .flashWeN(flashWeN)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor: address at WE# fall, data at WE# rise
  always @(negedge clk) begin
    if (rstN) begin
      if (flashCeN !== 1'b0) check(0, "R1 chip enable low", 32'(flashCeN), 0);
      if (!flashWeN) begin
        lowLen++;
        if (prevWe && recN < 16) recAddr[recN] = flashAddr;
        if (!(flashOeN && flashDqOe)) check(0, "R10 OE high and bus driven", {flashOeN, flashDqOe}, 2'b11);
      end else if (!prevWe) begin
        check(lowLen == 1, "R10 WE low width", lowLen, 1);
        if (recN < 16) begin
          check(recAddr[recN] == flashAddr, "R10 address held", flashAddr, recAddr[recN]);
          recData[recN] = flashDqOut;
        end
        recN++;
        lowLen = 0;
      end
      if (done) doneCnt++;
    end
    prevWe = flashWeN;
  end

  task automatic clearRec();
    recN = 0;
    doneCnt = 0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input bit r, input bit p, input bit e, input bit s);
    @(negedge clk);
    rdReq = r; pgmReq = p; ersReq = e; dataStrobe = s;
    @(negedge clk);
    rdReq = 0; pgmReq = 0; ersReq = 0; dataStrobe = 0;
  endtask

  task automatic waitDone(input string req);
    int t = 0;
    while (!done && t < 200) begin
      @(negedge clk);
      t++;
    end
    check(done == 1'b1, req, 32'(done), 1);
    check(busy == 1'b0, "R6 busy low with done", 32'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", 32'(done), 0);
  endtask

  task automatic checkWrite(input int idx, input logic [21:0] a, input logic [15:0] d, input string req);
    check(recAddr[idx] == a, req, recAddr[idx], a);
    check(recData[idx] == d, req, recData[idx], d);
  endtask

  task automatic testReset();
    check(flashWeN && flashOeN && !flashDqOe && !flashCeN, "R1 idle pins",
          {flashWeN, flashOeN, flashDqOe, flashCeN}, 4'b1100);
    check(!busy && !done, "R1 status after reset", {busy, done}, 0);
  endtask

  task automatic testProgram();
    clearRec();
    hostSector = 7'h15; hostOffset = 15'h1234; hostData = 16'h0;
    pulse(0, 1, 0, 0);
    cyc(15);
    check(recN == 3, "R2 three writes before hold", recN, 3);
    checkWrite(0, 22'h555, 16'hAA, "R2 write 1");
    checkWrite(1, 22'h2AA, 16'h55, "R2 write 2");
    checkWrite(2, 22'h555, 16'hA0, "R2 write 3");
    check(busy && flashWeN, "R3 held busy, WE high", {busy, flashWeN}, 2'b11);
    hostData = 16'hBEEF;
    pulse(0, 0, 0, 1);
    hostData = 16'h1111;
    waitDone("R6 program done");
    check(recN == 4, "R3 fourth write after strobe", recN, 4);
    checkWrite(3, {7'h15, 15'h1234}, 16'hBEEF, "R4 user write");
  endtask

  task automatic testEraseIgnore();
    clearRec();
    pulse(0, 0, 1, 0);
    cyc(5);
    hostSector = 7'h7F; hostOffset = 15'h7FFF;
    pulse(1, 1, 1, 1);
    waitDone("R6 erase done");
    cyc(20);
    check(recN == 6, "R8 erase writes only", recN, 6);
    checkWrite(0, 22'h555, 16'hAA, "R5 erase 1");
    checkWrite(1, 22'h2AA, 16'h55, "R5 erase 2");
    checkWrite(2, 22'h555, 16'h80, "R5 erase 3");
    checkWrite(3, 22'h555, 16'hAA, "R5 erase 4");
    checkWrite(4, 22'h2AA, 16'h55, "R5 erase 5");
    checkWrite(5, 22'h555, 16'h10, "R5 erase 6");
    check(doneCnt == 1 && !busy, "R8 no extra operation", doneCnt, 1);
  endtask

  task automatic testRead();
    clearRec();
    hostSector = 7'h2C; hostOffset = 15'h0ABC;
    pulse(1, 0, 0, 0);
    check(!flashOeN && flashWeN && !flashDqOe, "R7 read pins", {flashOeN, flashWeN, flashDqOe}, 3'b010);
    check(flashAddr == {7'h2C, 15'h0ABC}, "R7 read address", flashAddr, {7'h2C, 15'h0ABC});
    waitDone("R7 read done");
    check(rdData == (16'({7'h2C, 15'h0ABC}) ^ 16'h5A5A), "R7 read data", rdData, 16'({7'h2C, 15'h0ABC}) ^ 16'h5A5A);
    check(recN == 0, "R7 read has no writes", recN, 0);
  endtask

  task automatic testPriority();
    clearRec();
    pulse(1, 1, 1, 0);
    waitDone("R9 erase wins");
    check(recN == 6, "R9 erase count", recN, 6);
    checkWrite(2, 22'h555, 16'h80, "R9 erase command byte");
    clearRec();
    pulse(1, 1, 0, 0);
    cyc(15);
    check(busy && recN == 3, "R9 program over read", recN, 3);
    checkWrite(2, 22'h555, 16'hA0, "R9 program command byte");
    hostSector = 7'h01; hostOffset = 15'h0002; hostData = 16'h1357;
    pulse(0, 0, 0, 1);
    waitDone("R9 program done");
    checkWrite(3, {7'h01, 15'h0002}, 16'h1357, "R4 second user write");
  endtask

  task automatic testStrayStrobe();
    clearRec();
    pulse(0, 0, 0, 1);
    cyc(15);
    check(recN == 0 && !busy && doneCnt == 0, "R11 stray strobe ignored", {recN[7:0], busy, doneCnt[7:0]}, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    testReset();
    testProgram();
    testEraseIgnore();
    testRead();
    testPriority();
    testStrayStrobe();
    summary();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      check(0, "watchdog", cycles, 100000);
      summary();
    end
  end

endmodule